// File: doc/BRIEF.md
# Four-Point Radix-4 FFT Butterfly

This block transforms a group of four complex samples into their four-point discrete Fourier transform. Each sample has a 16-bit two's-complement real part and a 16-bit two's-complement imaginary part. The work is split into two add/subtract stages, and each stage ends in a register. The first stage forms the sums and differences of the sample pairs (0,2) and (1,3). The second stage combines these partial results. The rotation by ±j needs no multiplier: the real and imaginary parts of one partial result are swapped and one of them changes sign.

The block accepts a new group on every clock cycle that has `in_valid` high. The matching result appears two cycles later with `out_valid` high. Every intermediate and final sum is clamped to the signed 16-bit range, and `ovfl` reports, alongside the result, whether any of the sixteen operations had to be clamped. Rotation by general twiddle factors is not done here; a complex multiplier placed downstream applies it.

Top module: `fft4_radix4`

## Requirements
- R1: In the absence of clamping, bin 0 of the output equals a0 + a1 + a2 + a3, computed separately on the real and imaginary parts. Sample k and bin k occupy bits [16k+15:16k] of their packed buses.
- R2: In the absence of clamping, bin 2 equals (a0 + a2) − (a1 + a3), on the real and imaginary parts separately.
- R3: Bin 1 has real part (a0r − a2r) + (a1i − a3i) and imaginary part (a0i − a2i) − (a1r − a3r). This is the difference term minus j times the second difference term.
- R4: Bin 3 has real part (a0r − a2r) − (a1i − a3i) and imaginary part (a0i − a2i) + (a1r − a3r).
- R5: `out_valid` rises exactly two rising clock edges after the edge that captures a group with `in_valid` high, and is low one edge after that capture.
- R6: Each first-stage result that leaves the range −32768..32767 is clamped to the nearer limit. The clamped value is then used in the second stage, and second-stage results are clamped in the same way.
- R7: `ovfl` is high together with `out_valid` exactly when at least one of the sixteen first- or second-stage operations for that group was clamped. It is low in every cycle where `out_valid` is low.
- R8: While no new result is due, `out_re` and `out_im` keep their last values, whatever data is present on the input buses with `in_valid` low.
- R9: While `rst_n` is low and after its release, `out_valid`, `ovfl`, `out_re` and `out_im` read zero until the first result arrives.
- R10: Groups presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The input buses carry a group to transform this cycle |
| in_re | input | 64 | Real parts of samples 0..3, sample k at bits [16k+15:16k] |
| in_im | input | 64 | Imaginary parts of samples 0..3, same packing |
| out_valid | output | 1 | The output buses carry a new result this cycle |
| out_re | output | 64 | Real parts of bins 0..3, bin k at bits [16k+15:16k] |
| out_im | output | 64 | Imaginary parts of bins 0..3, same packing |
| ovfl | output | 1 | Clamping occurred while this result was computed |

## Verification
Some properties are checked on every cycle:
- the two-cycle alignment between `in_valid` and `out_valid`;
- that `ovfl` is never high without a result;
- that the output buses hold still between results;
- that, for every unclamped result, bins 0 and 2 match the sums of the delayed inputs.

The rotated bins 1 and 3 are checked only by the bench's scenarios, as are the exact clamp values at each stage, the choice between positive and negative limits, and the case where only the second stage overflows. The reset values and back-to-back ordering are also left to those scenarios.

// File: rtl/fft4_pkg.sv
// Shared constants for the four-point butterfly.
// Assumes: samples are signed two's-complement, packed sample 0 in the low bits.
package fft4_pkg;
    // Default width of one real or imaginary part.
    localparam int unsigned FFT4_DW  = 16;
    // Number of complex points handled per group (fixed radix).
    localparam int unsigned FFT4_PTS = 4;
endpackage

// File: rtl/fft4_addsub.sv
// Saturating signed adder or subtractor, chosen at elaboration by SUB.
// Assumes: x and y are DW-bit two's-complement; output clamps to the
// DW-bit signed range and ovf flags that a clamp happened.
module fft4_addsub #(
    parameter int unsigned DW  = fft4_pkg::FFT4_DW,
    parameter bit          SUB = 1'b0
) (
    input  logic signed [DW-1:0] x,
    input  logic signed [DW-1:0] y,
    output logic signed [DW-1:0] z,
    output logic                 ovf
);
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    // Pick the operation once; both forms widen by one bit first.
    generate
        if (SUB) begin : g_sub
            assign wide = {x[DW-1], x} - {y[DW-1], y};
        end else begin : g_add
            assign wide = {x[DW-1], x} + {y[DW-1], y};
        end
    endgenerate

    // Detect leaving the range and clamp toward the sign of the true result.
    always_comb begin
        ovf = wide[DW] ^ wide[DW-1];
        if (ovf) begin
            z = wide[DW] ? MINV : MAXV;
        end else begin
            z = wide[DW-1:0];
        end
    end
endmodule

// File: rtl/fft4_stage1.sv
// First butterfly stage: b0=a0+a2, b1=a0-a2, b2=a1+a3, b3=a1-a3 on real and
// imaginary parts independently, registered.
// Assumes: data registers load only on in_valid; flag register clears otherwise.
module fft4_stage1 #(
    parameter int unsigned DW = fft4_pkg::FFT4_DW
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0]   in_re,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0]   in_im,
    output logic                               b_valid,
    output logic                               b_ovf,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0]   b_re,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0]   b_im
);
    localparam int unsigned PTS  = fft4_pkg::FFT4_PTS;
    localparam int unsigned HALF = PTS / 2;
    localparam int unsigned VW   = PTS * DW;

    logic [VW-1:0]  sum_re;
    logic [VW-1:0]  sum_im;
    logic [PTS-1:0] ov_re;
    logic [PTS-1:0] ov_im;

    // Pair p with p+HALF; op 0 adds, op 1 subtracts; result lands at 2p+op.
    generate
        for (genvar p = 0; p < HALF; p++) begin : g_pair
            for (genvar op = 0; op < 2; op++) begin : g_op
                localparam int unsigned O = 2 * p + op;
                fft4_addsub #(.DW(DW), .SUB(op == 1)) u_re (
                    .x  (in_re[p*DW +: DW]),
                    .y  (in_re[(p+HALF)*DW +: DW]),
                    .z  (sum_re[O*DW +: DW]),
                    .ovf(ov_re[O])
                );
                fft4_addsub #(.DW(DW), .SUB(op == 1)) u_im (
                    .x  (in_im[p*DW +: DW]),
                    .y  (in_im[(p+HALF)*DW +: DW]),
                    .z  (sum_im[O*DW +: DW]),
                    .ovf(ov_im[O])
                );
            end
        end
    endgenerate

    // Register the partial results and the clamp flag for this group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_ovf   <= 1'b0;
            b_re    <= '0;
            b_im    <= '0;
        end else begin
            b_valid <= in_valid;
            b_ovf   <= in_valid & ((|ov_re) | (|ov_im));
            if (in_valid) begin
                b_re <= sum_re;
                b_im <= sum_im;
            end
        end
    end
endmodule

// File: rtl/fft4_stage2.sv
// Second butterfly stage: X0=b0+b2, X2=b0-b2, X1=b1-j*b3, X3=b1+j*b3, where
// the j rotation swaps the parts of b3 and flips the operation per part.
// Assumes: b_ovf already reports first-stage clamps; registered output.
module fft4_stage2 #(
    parameter int unsigned DW = fft4_pkg::FFT4_DW
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               b_valid,
    input  logic                               b_ovf,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0]   b_re,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0]   b_im,
    output logic                               x_valid,
    output logic                               x_ovf,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0]   x_re,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0]   x_im
);
    localparam int unsigned PTS = fft4_pkg::FFT4_PTS;
    localparam int unsigned VW  = PTS * DW;

    logic [VW-1:0]  res_re;
    logic [VW-1:0]  res_im;
    logic [PTS-1:0] ov_re;
    logic [PTS-1:0] ov_im;

    // op 0 builds bins 0 and 1, op 1 builds bins 2 and 3.
    generate
        for (genvar op = 0; op < 2; op++) begin : g_op
            localparam int unsigned E = 2 * op;
            localparam int unsigned D = 2 * op + 1;
            // Even bin: b0 +/- b2 on each part.
            fft4_addsub #(.DW(DW), .SUB(op == 1)) u_even_re (
                .x  (b_re[0 +: DW]),
                .y  (b_re[2*DW +: DW]),
                .z  (res_re[E*DW +: DW]),
                .ovf(ov_re[E])
            );
            fft4_addsub #(.DW(DW), .SUB(op == 1)) u_even_im (
                .x  (b_im[0 +: DW]),
                .y  (b_im[2*DW +: DW]),
                .z  (res_im[E*DW +: DW]),
                .ovf(ov_im[E])
            );
            // Odd bin real: b1r +/- b3i (plus for bin 1, minus for bin 3).
            fft4_addsub #(.DW(DW), .SUB(op == 1)) u_odd_re (
                .x  (b_re[DW +: DW]),
                .y  (b_im[3*DW +: DW]),
                .z  (res_re[D*DW +: DW]),
                .ovf(ov_re[D])
            );
            // Odd bin imaginary: b1i -/+ b3r (minus for bin 1, plus for bin 3).
            fft4_addsub #(.DW(DW), .SUB(op == 0)) u_odd_im (
                .x  (b_im[DW +: DW]),
                .y  (b_re[3*DW +: DW]),
                .z  (res_im[D*DW +: DW]),
                .ovf(ov_im[D])
            );
        end
    endgenerate

    // Register the bins and merge this stage's clamps with the earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_valid <= 1'b0;
            x_ovf   <= 1'b0;
            x_re    <= '0;
            x_im    <= '0;
        end else begin
            x_valid <= b_valid;
            x_ovf   <= b_valid & (b_ovf | (|ov_re) | (|ov_im));
            if (b_valid) begin
                x_re <= res_re;
                x_im <= res_im;
            end
        end
    end
endmodule

// File: rtl/fft4_radix4.sv
// Four-point radix-4 butterfly: two registered saturating add/subtract stages,
// natural output order, one result per cycle, two cycles of latency.
// Assumes: synchronous active-low reset; in_valid qualifies each group.
module fft4_radix4 #(
    parameter int unsigned DW = fft4_pkg::FFT4_DW
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0] in_re,
    input  logic [fft4_pkg::FFT4_PTS*DW-1:0] in_im,
    output logic                             out_valid,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0] out_re,
    output logic [fft4_pkg::FFT4_PTS*DW-1:0] out_im,
    output logic                             ovfl
);
    localparam int unsigned VW = fft4_pkg::FFT4_PTS * DW;

    logic          s1_valid;
    logic          s1_ovf;
    logic [VW-1:0] s1_re;
    logic [VW-1:0] s1_im;

    // Pair sums and differences.
    fft4_stage1 #(.DW(DW)) u_stage1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_re   (in_re),
        .in_im   (in_im),
        .b_valid (s1_valid),
        .b_ovf   (s1_ovf),
        .b_re    (s1_re),
        .b_im    (s1_im)
    );

    // Combination with the j rotation.
    fft4_stage2 #(.DW(DW)) u_stage2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .b_valid(s1_valid),
        .b_ovf  (s1_ovf),
        .b_re   (s1_re),
        .b_im   (s1_im),
        .x_valid(out_valid),
        .x_ovf  (ovfl),
        .x_re   (out_re),
        .x_im   (out_im)
    );
endmodule

// File: rtl/fft4_radix4_chk.sv
// Cycle-by-cycle checks on the butterfly's ports, attached by bind.
// Assumes: it keeps its own two-deep copy of accepted inputs.
module fft4_radix4_chk #(
    parameter int unsigned DW = fft4_pkg::FFT4_DW
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             in_valid,
    input logic [fft4_pkg::FFT4_PTS*DW-1:0] in_re,
    input logic [fft4_pkg::FFT4_PTS*DW-1:0] in_im,
    input logic                             out_valid,
    input logic [fft4_pkg::FFT4_PTS*DW-1:0] out_re,
    input logic [fft4_pkg::FFT4_PTS*DW-1:0] out_im,
    input logic                             ovfl
);
    localparam int unsigned VW = fft4_pkg::FFT4_PTS * DW;
    localparam int unsigned EW = DW + 3;

    logic [1:0]    vsh;
    logic [VW-1:0] d1_re, d1_im, d2_re, d2_im;
    logic [EW-1:0] e0_re, e0_im, e2_re, e2_im;

    function automatic logic [EW-1:0] sx(input logic [DW-1:0] v);
        return {{3{v[DW-1]}}, v};
    endfunction

    // Track accepted groups and their data along the expected pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsh   <= '0;
            d1_re <= '0;
            d1_im <= '0;
            d2_re <= '0;
            d2_im <= '0;
        end else begin
            vsh <= {vsh[0], in_valid};
            if (in_valid) begin
                d1_re <= in_re;
                d1_im <= in_im;
            end
            if (vsh[0]) begin
                d2_re <= d1_re;
                d2_im <= d1_im;
            end
        end
    end

    // Unclamped reference sums for bins 0 and 2.
    always_comb begin
        e0_re = sx(d2_re[0+:DW]) + sx(d2_re[DW+:DW]) + sx(d2_re[2*DW+:DW]) + sx(d2_re[3*DW+:DW]);
        e0_im = sx(d2_im[0+:DW]) + sx(d2_im[DW+:DW]) + sx(d2_im[2*DW+:DW]) + sx(d2_im[3*DW+:DW]);
        e2_re = sx(d2_re[0+:DW]) - sx(d2_re[DW+:DW]) + sx(d2_re[2*DW+:DW]) - sx(d2_re[3*DW+:DW]);
        e2_im = sx(d2_im[0+:DW]) - sx(d2_im[DW+:DW]) + sx(d2_im[2*DW+:DW]) - sx(d2_im[3*DW+:DW]);
    end

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsh[1]);

    p_ovfl_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovfl |-> out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_re) && $stable(out_im)));

    p_bin0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ovfl) |-> (sx(out_re[0+:DW]) == e0_re && sx(out_im[0+:DW]) == e0_im));

    p_bin2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !ovfl) |-> (sx(out_re[2*DW+:DW]) == e2_re && sx(out_im[2*DW+:DW]) == e2_im));
endmodule

bind fft4_radix4 fft4_radix4_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_re    (in_re),
    .in_im    (in_im),
    .out_valid(out_valid),
    .out_re   (out_re),
    .out_im   (out_im),
    .ovfl     (ovfl)
);

// File: tb/fft4_radix4_test.sv
// Directed bench for the four-point butterfly; each scenario task checks itself.
module fft4_radix4_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int VW = 4 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_re = '0;
    logic [VW-1:0] in_im = '0;
    logic          out_valid;
    logic [VW-1:0] out_re;
    logic [VW-1:0] out_im;
    logic          ovfl;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    fft4_radix4 uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .ovfl(ovfl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack four signed values, sample 0 in the low bits.
    function automatic logic [VW-1:0] pk(input int v0, input int v1, input int v2, input int v3);
        return {16'(v3), 16'(v2), 16'(v1), 16'(v0)};
    endfunction

    function automatic int sat(input int v, inout bit ov);
        if (v > 32767) begin ov = 1'b1; return 32767; end
        if (v < -32768) begin ov = 1'b1; return -32768; end
        return v;
    endfunction

    // Expected transform built from the requirement formulas.
    task automatic model(input logic [VW-1:0] ar, input logic [VW-1:0] ai,
                         output logic [VW-1:0] xr, output logic [VW-1:0] xi, output bit ov);
        int a_r[4], a_i[4], b_r[4], b_i[4];
        ov = 1'b0;
        for (int k = 0; k < 4; k++) begin
            a_r[k] = int'($signed(ar[k*DW +: DW]));
            a_i[k] = int'($signed(ai[k*DW +: DW]));
        end
        b_r[0] = sat(a_r[0] + a_r[2], ov); b_i[0] = sat(a_i[0] + a_i[2], ov);
        b_r[1] = sat(a_r[0] - a_r[2], ov); b_i[1] = sat(a_i[0] - a_i[2], ov);
        b_r[2] = sat(a_r[1] + a_r[3], ov); b_i[2] = sat(a_i[1] + a_i[3], ov);
        b_r[3] = sat(a_r[1] - a_r[3], ov); b_i[3] = sat(a_i[1] - a_i[3], ov);
        xr = pk(sat(b_r[0] + b_r[2], ov), sat(b_r[1] + b_i[3], ov),
                sat(b_r[0] - b_r[2], ov), sat(b_r[1] - b_i[3], ov));
        xi = pk(sat(b_i[0] + b_i[2], ov), sat(b_i[1] - b_r[3], ov),
                sat(b_i[0] - b_i[2], ov), sat(b_i[1] + b_r[3], ov));
    endtask

    task automatic chk(input string req, input logic ev, input logic [VW-1:0] er,
                       input logic [VW-1:0] ei, input logic eov);
        n_chk++;
        if (out_valid !== ev || out_re !== er || out_im !== ei || ovfl !== eov) begin
            n_bad++;
            $display("FAIL %s: got valid=%b re=%h im=%h ovfl=%b, expected valid=%b re=%h im=%h ovfl=%b",
                     req, out_valid, out_re, out_im, ovfl, ev, er, ei, eov);
        end
    endtask

    // One group: checks the gap cycle (R5) then the result.
    task automatic run_one(input string req, input logic [VW-1:0] ar, input logic [VW-1:0] ai);
        logic [VW-1:0] xr, xi, pr, pi;
        bit ov;
        model(ar, ai, xr, xi, ov);
        pr = out_re; pi = out_im;
        @(negedge clk); in_valid = 1'b1; in_re = ar; in_im = ai;
        @(negedge clk); in_valid = 1'b0;
        chk({req, " R5 gap cycle"}, 1'b0, pr, pi, 1'b0);
        @(negedge clk);
        chk(req, 1'b1, xr, xi, ov);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 during reset", 1'b0, '0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 after release", 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_basic;
        run_one("R1 R2 R3 R4 impulse", pk(100, 0, 0, 0), pk(0, 0, 0, 0));
        run_one("R3 R4 rotation of a1", pk(0, 1000, 0, 0), pk(0, 0, 0, 0));
        run_one("R3 R4 rotation of a3 imag", pk(0, 0, 0, 0), pk(0, 0, 0, 700));
        run_one("R1 R2 R3 R4 mixed", pk(1234, -567, 890, -1111), pk(-42, 3000, -2500, 17));
        run_one("R1 R2 R3 R4 negative", pk(-8000, -7000, 6000, 5000), pk(4000, -3000, -2000, 1000));
    endtask

    task automatic t_sat;
        run_one("R6 R7 first stage positive clamp", pk(32767, 0, 100, 0), pk(0, 0, 0, 0));
        run_one("R6 R7 first stage negative clamp", pk(-30000, 0, -30000, 0), pk(0, 0, 0, 0));
        run_one("R6 R7 second stage only", pk(20000, 20000, 0, 0), pk(0, 0, 0, 0));
        run_one("R6 R7 rotated bin clamp", pk(16000, 0, -16000, 0), pk(0, 20000, 0, -20000));
        run_one("R7 clean after clamp", pk(1, 2, 3, 4), pk(5, 6, 7, 8));
    endtask

    task automatic t_stream;
        logic [VW-1:0] ar[3], ai[3], xr[3], xi[3];
        bit ov[3];
        ar[0] = pk(10, 20, 30, 40);    ai[0] = pk(-1, -2, -3, -4);
        ar[1] = pk(32000, 1, 32000, 1); ai[1] = pk(0, 0, 0, 0);
        ar[2] = pk(-5, 600, 7, -800);  ai[2] = pk(900, -10, 11, 12);
        for (int k = 0; k < 3; k++) model(ar[k], ai[k], xr[k], xi[k], ov[k]);
        @(negedge clk); in_valid = 1'b1; in_re = ar[0]; in_im = ai[0];
        @(negedge clk); in_re = ar[1]; in_im = ai[1];
        @(negedge clk); in_re = ar[2]; in_im = ai[2];
        chk("R10 stream first", 1'b1, xr[0], xi[0], ov[0]);
        @(negedge clk); in_valid = 1'b0;
        chk("R10 stream second", 1'b1, xr[1], xi[1], ov[1]);
        @(negedge clk);
        chk("R10 stream third", 1'b1, xr[2], xi[2], ov[2]);
    endtask

    task automatic t_hold;
        logic [VW-1:0] xr, xi;
        bit ov;
        run_one("R8 setup", pk(300, -200, 100, 50), pk(7, 8, 9, 10));
        model(pk(300, -200, 100, 50), pk(7, 8, 9, 10), xr, xi, ov);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_re = pk(32767, -32768, 12345 + k, -1);
            in_im = pk(-32768, 32767, 1, 2);
            chk("R8 idle hold", 1'b0, xr, xi, 1'b0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_sat();
        t_stream();
        t_hold();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule